// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a memory-mapped general-purpose I/O controller for a set of pins (32 by default). Software reaches it through a single-cycle register bus made of an address, a write enable, write data and combinational read data. Through this bus it drives output values and per-pin direction, and it reads back the pin inputs after synchronization. Pull enable and pull select settings are held in plain storage registers and brought out to the pad ring.

Each pin can watch for its own interrupt condition. The condition is chosen from three configuration bit-planes: a detect-kind plane (edge or level), a polarity plane, and an any-edge plane. The available conditions are rising edge, falling edge, both edges, level high and level low. A detected event is latched in a pending register. Software acknowledges it by writing ones to a clear register. A mask plane controls which pending bits reach the single combined interrupt line. The mask does not stop events from being latched.

There is no back-pressure anywhere. Every bus access completes in the cycle it is presented, and the pins are sampled on every clock.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, so all pins are inputs (`pin_dir`=0), `pin_out`=0, pull outputs are 0, nothing is pending and `irq`=0.
- R2: Offset 0x00 is the output register, written directly and read back, and it drives `pin_out`. Offset 0x08 is the direction register (1 = pin driven by `pin_out`), which drives `pin_dir`.
- R3: A write to 0x10 sets every output bit written as 1. A write to 0x14 clears every output bit written as 1. Bits written as 0 at either offset keep their value.
- R4: A read of 0x04 returns the pins through a two-flop synchronizer. A pin change before clock edge k is readable after edge k+1.
- R5: With detect-kind (0x34) bit 0 and any-edge (0x38) bit 0, polarity (0x3C) bit 0 latches a rising edge and polarity bit 1 latches a falling edge. The pending bit is set at the edge after the synchronized value changes.
- R6: With detect-kind bit 0 and any-edge bit 1, any transition latches an event, whatever the polarity bit holds. With no transition, nothing is latched.
- R7: With detect-kind bit 1, polarity 0 means active-high and polarity 1 means active-low. While the level stays active, the pending bit is set again on every cycle, so a clear does not remove it (set beats clear).
- R8: Only pins whose enable bit (0x20) is 1 latch events. Activity on a disabled pin leaves its pending bit at 0.
- R9: Offset 0x24 reads the pending bits in one access. Writing 1 to a bit of 0x30 clears that pending bit, and writing 0 has no effect.
- R10: `irq` is high exactly when some pending bit has its mask bit (0x2C) at 0. A masked pin still latches its pending bit.
- R11: Pull-enable (0x18) and pull-select (0x1C) are read/write storage that drive `pull_en` and `pull_sel`.
- R12: Reads of 0x10, 0x14, 0x30 and any unmapped offset (for example 0x0C) return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Register byte offset |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | NPINS | Pad input values, asynchronous |
| pin_out | output | NPINS | Output values to pads |
| pin_dir | output | NPINS | Per-pin output enable |
| pull_en | output | NPINS | Per-pin pull enable |
| pull_sel | output | NPINS | Per-pin pull select |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: 32 pins on a 32-bit bus, with the two-stage synchronizer. The full pin count lets the vector table give each trigger case its own pin, so no case disturbs another. It also lets the directed tests reach the top pin (31) and full-width set, clear and clear-all patterns. The two-stage depth fixes the cycle on which data-in and the pending bits change, and the bench samples on that cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_DOUT  = 8'h00;
  localparam logic [ADDR_W-1:0] A_DIN   = 8'h04;
  localparam logic [ADDR_W-1:0] A_DIR   = 8'h08;
  localparam logic [ADDR_W-1:0] A_DSET  = 8'h10;
  localparam logic [ADDR_W-1:0] A_DCLR  = 8'h14;
  localparam logic [ADDR_W-1:0] A_PEN   = 8'h18;
  localparam logic [ADDR_W-1:0] A_PSEL  = 8'h1C;
  localparam logic [ADDR_W-1:0] A_IEN   = 8'h20;
  localparam logic [ADDR_W-1:0] A_ISTAT = 8'h24;
  localparam logic [ADDR_W-1:0] A_IMASK = 8'h2C;
  localparam logic [ADDR_W-1:0] A_ICLR  = 8'h30;
  localparam logic [ADDR_W-1:0] A_ITYPE = 8'h34;
  localparam logic [ADDR_W-1:0] A_IBOTH = 8'h38;
  localparam logic [ADDR_W-1:0] A_ILVL  = 8'h3C;

  // per-pin trigger selection gathered from the three bit-planes
  typedef struct packed {
    logic is_level;
    logic invert;
    logic any_edge;
  } trig_cfg_t;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] smp,
  input  logic [N-1:0] en,
  input  logic [N-1:0] kind,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] anyedge,
  output logic [N-1:0] evt
);
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= smp;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    trig_cfg_t cfg;
    logic rise, fall, hit;
    assign cfg  = '{is_level: kind[i], invert: pol[i], any_edge: anyedge[i]};
    assign rise = smp[i] & ~prev[i];
    assign fall = ~smp[i] & prev[i];
    always_comb begin
      if (cfg.is_level)      hit = smp[i] ^ cfg.invert;
      else if (cfg.any_edge) hit = rise | fall;
      else if (cfg.invert)   hit = fall;
      else                   hit = rise;
    end
    assign evt[i] = en[i] & hit;
  end
endmodule

// File: rtl/gpio_status.sv
module gpio_status #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  // a fresh event outranks an acknowledge in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr) | evt;
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int NPINS      = 32,
  parameter int DW         = 32,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_dir,
  output logic [NPINS-1:0]  pull_en,
  output logic [NPINS-1:0]  pull_sel,
  output logic              irq
);
  logic [NPINS-1:0] wbits;
  logic [NPINS-1:0] dout_q, dir_q, pen_q, psel_q;
  logic [NPINS-1:0] ien_q, imask_q, itype_q, iboth_q, ilvl_q;
  logic [NPINS-1:0] din_s, evt, clr_v, pend;

  assign wbits = reg_wdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q  <= '0;
      dir_q   <= '0;
      pen_q   <= '0;
      psel_q  <= '0;
      ien_q   <= '0;
      imask_q <= '0;
      itype_q <= '0;
      iboth_q <= '0;
      ilvl_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_DOUT:  dout_q  <= wbits;
        A_DSET:  dout_q  <= dout_q | wbits;
        A_DCLR:  dout_q  <= dout_q & ~wbits;
        A_DIR:   dir_q   <= wbits;
        A_PEN:   pen_q   <= wbits;
        A_PSEL:  psel_q  <= wbits;
        A_IEN:   ien_q   <= wbits;
        A_IMASK: imask_q <= wbits;
        A_ITYPE: itype_q <= wbits;
        A_IBOTH: iboth_q <= wbits;
        A_ILVL:  ilvl_q  <= wbits;
        default: ;
      endcase
    end
  end

  assign clr_v = (reg_we && reg_addr == A_ICLR) ? wbits : '0;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(din_s)
  );

  gpio_detect #(.N(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .smp(din_s), .en(ien_q),
    .kind(itype_q), .pol(ilvl_q), .anyedge(iboth_q), .evt(evt)
  );

  gpio_status #(.N(NPINS)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(clr_v), .pend(pend)
  );

  always_comb begin
    case (reg_addr)
      A_DOUT:  reg_rdata = DW'(dout_q);
      A_DIN:   reg_rdata = DW'(din_s);
      A_DIR:   reg_rdata = DW'(dir_q);
      A_PEN:   reg_rdata = DW'(pen_q);
      A_PSEL:  reg_rdata = DW'(psel_q);
      A_IEN:   reg_rdata = DW'(ien_q);
      A_ISTAT: reg_rdata = DW'(pend);
      A_IMASK: reg_rdata = DW'(imask_q);
      A_ITYPE: reg_rdata = DW'(itype_q);
      A_IBOTH: reg_rdata = DW'(iboth_q);
      A_ILVL:  reg_rdata = DW'(ilvl_q);
      default: reg_rdata = '0;
    endcase
  end

  assign pin_out  = dout_q;
  assign pin_dir  = dir_q;
  assign pull_en  = pen_q;
  assign pull_sel = psel_q;
  assign irq      = |(pend & ~imask_q);
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NPINS = 32,
  parameter int DW    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [DW-1:0]     reg_wdata,
  input logic [NPINS-1:0]  pin_out,
  input logic [NPINS-1:0]  pend,
  input logic [NPINS-1:0]  evt,
  input logic [NPINS-1:0]  imask,
  input logic              irq
);
  logic ack_wr, set_wr, clr_wr;
  assign ack_wr = reg_we && reg_addr == A_ICLR;
  assign set_wr = reg_we && reg_addr == A_DSET;
  assign clr_wr = reg_we && reg_addr == A_DCLR;

  AST_SET_DRIVES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> ((pin_out & $past(reg_wdata[NPINS-1:0])) == $past(reg_wdata[NPINS-1:0]))); // R3
  AST_CLR_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> ((pin_out & $past(reg_wdata[NPINS-1:0])) == '0)); // R3
  AST_ACK_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && (&reg_wdata[NPINS-1:0]) && evt == '0) |=> pend == '0); // R9
  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_wr && evt == '0) |=> $stable(pend)); // R9
  AST_EVENT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend & $past(evt)) == $past(evt))); // R7
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend != '0)); // R10
  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&imask) |-> !irq); // R10
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .pin_out(pin_out), .pend(pend), .evt(evt),
  .imask(imask_q), .irq(irq)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [N-1:0]  pin_in = '0;
  logic [N-1:0]  pin_out, pin_dir, pull_en, pull_sel;
  logic          irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_dir(pin_dir), .pull_en(pull_en),
    .pull_sel(pull_sel), .irq(irq)
  );

  // type, polarity, any-edge, start level, end level, expected pending
  localparam logic [5:0] VEC [12] = '{
    6'b000_01_1,  // R5 rising seen
    6'b000_10_0,  // R5 rising ignores fall
    6'b010_10_1,  // R5 falling seen
    6'b010_01_0,  // R5 falling ignores rise
    6'b011_01_1,  // R6 any edge, polarity 1
    6'b001_10_1,  // R6 any edge, polarity 0
    6'b100_11_1,  // R7 level high active
    6'b100_00_0,  // R7 level high idle
    6'b110_00_1,  // R7 level low active
    6'b110_11_0,  // R7 level low idle
    6'b000_00_0,  // R5 no change
    6'b001_11_0   // R6 no change
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic rdchk(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] v;
    rd(a, v);
    check(v == exp, req, v, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    rdchk(8'h00, 32'h0, "R1 dout");
    rdchk(8'h24, 32'h0, "R1 status");
    rdchk(8'h20, 32'h0, "R1 enable");
    check(pin_dir == '0 && pin_out == '0 && pull_en == '0 && pull_sel == '0,
          "R1 pins", {pin_dir[15:0], pin_out[15:0]}, 32'h0);
    check(irq == 1'b0, "R1 irq", {31'h0, irq}, 32'h0);

    // trigger-mode table, one pin per vector
    for (int i = 0; i < 12; i++) begin
      logic [31:0] b;
      logic [5:0]  e;
      b = 32'h1 << i;
      e = VEC[i];
      wr(8'h20, 32'h0);
      pin_in = '0;
      pin_in[i] = e[2];
      cyc(4);
      wr(8'h34, e[5] ? b : 32'h0);
      wr(8'h3C, e[4] ? b : 32'h0);
      wr(8'h38, e[3] ? b : 32'h0);
      wr(8'h30, 32'hFFFF_FFFF);
      wr(8'h20, b);
      pin_in[i] = e[1];
      cyc(5);
      rdchk(8'h24, e[0] ? b : 32'h0, $sformatf("R5/R6/R7 vector %0d status", i));
      check(irq == e[0], $sformatf("R10 vector %0d irq", i), {31'h0, irq}, {31'h0, e[0]});
    end
    wr(8'h20, 32'h0);
    wr(8'h34, 32'h0); wr(8'h3C, 32'h0); wr(8'h38, 32'h0);
    pin_in = '0;
    cyc(4);
    wr(8'h30, 32'hFFFF_FFFF);

    // R2 direct output and direction
    wr(8'h00, 32'h0000_00F0);
    rdchk(8'h00, 32'h0000_00F0, "R2 dout readback");
    check(pin_out == 32'h0000_00F0, "R2 pin_out", pin_out, 32'h0000_00F0);
    wr(8'h08, 32'h8000_00FF);
    check(pin_dir == 32'h8000_00FF, "R2 pin_dir", pin_dir, 32'h8000_00FF);
    rdchk(8'h08, 32'h8000_00FF, "R2 dir readback");

    // R3 set and clear with zero bits untouched
    wr(8'h10, 32'h8000_000F);
    check(pin_out == 32'h8000_00FF, "R3 set", pin_out, 32'h8000_00FF);
    wr(8'h14, 32'h0000_0030);
    check(pin_out == 32'h8000_00CF, "R3 clear", pin_out, 32'h8000_00CF);
    wr(8'h14, 32'hFFFF_FFFF);
    check(pin_out == 32'h0, "R3 clear all", pin_out, 32'h0);

    // R4 synchronizer latency
    @(negedge clk);
    reg_addr = 8'h04;
    pin_in = 32'hA5A5_0001;
    @(negedge clk); #1;
    check(reg_rdata == 32'h0, "R4 not yet visible", reg_rdata, 32'h0);
    @(negedge clk); #1;
    check(reg_rdata == 32'hA5A5_0001, "R4 visible", reg_rdata, 32'hA5A5_0001);
    pin_in = '0;
    cyc(4);

    // R8 disabled pin: toggle pin 31 in rising mode without enable
    wr(8'h20, 32'h0);
    pin_in[31] = 1'b1; cyc(4); pin_in[31] = 1'b0; cyc(4);
    rdchk(8'h24, 32'h0, "R8 disabled no status");

    // R9 and R10: latch pin 31 rising, mask, write-zero clear, write-one clear
    wr(8'h20, 32'h8000_0000);
    wr(8'h2C, 32'h8000_0000);
    pin_in[31] = 1'b1;
    cyc(5);
    rdchk(8'h24, 32'h8000_0000, "R10 masked still latches");
    check(irq == 1'b0, "R10 mask holds irq low", {31'h0, irq}, 32'h0);
    wr(8'h2C, 32'h0);
    check(irq == 1'b1, "R10 unmask raises irq", {31'h0, irq}, 32'h1);
    wr(8'h30, 32'h7FFF_FFFF);
    rdchk(8'h24, 32'h8000_0000, "R9 zero bit no effect");
    wr(8'h30, 32'h8000_0000);
    rdchk(8'h24, 32'h0, "R9 one bit clears");
    check(irq == 1'b0, "R10 irq drops", {31'h0, irq}, 32'h0);
    wr(8'h20, 32'h0);
    pin_in = '0;

    // R7 level re-trigger: pin 3 level high held active
    wr(8'h34, 32'h8);
    pin_in[3] = 1'b1;
    cyc(4);
    wr(8'h20, 32'h8);
    cyc(2);
    wr(8'h30, 32'h8);
    rdchk(8'h24, 32'h8, "R7 clear while active");
    pin_in[3] = 1'b0;
    cyc(4);
    wr(8'h30, 32'h8);
    rdchk(8'h24, 32'h0, "R7 clear after inactive");
    wr(8'h20, 32'h0);
    wr(8'h34, 32'h0);

    // R11 pull storage
    wr(8'h18, 32'h1234_5678);
    wr(8'h1C, 32'hCAFE_0001);
    rdchk(8'h18, 32'h1234_5678, "R11 pull enable");
    rdchk(8'h1C, 32'hCAFE_0001, "R11 pull select");
    check(pull_en == 32'h1234_5678 && pull_sel == 32'hCAFE_0001, "R11 pull pins",
          pull_sel, 32'hCAFE_0001);

    // R12 write-only and unmapped offsets
    wr(8'h00, 32'hFFFF_FFFF);
    rdchk(8'h10, 32'h0, "R12 set reads zero");
    rdchk(8'h14, 32'h0, "R12 clear reads zero");
    rdchk(8'h30, 32'h0, "R12 ack reads zero");
    rdchk(8'h0C, 32'h0, "R12 unmapped reads zero");

    // R1 again: reset mid-run returns everything to zero
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    rd(8'h00, v);
    check(v == 32'h0 && pin_dir == '0 && pull_en == '0, "R1 re-reset", v, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule